// File: doc/BRIEF.md
# Byte-Stream Control Port Write Decoder

This block sits behind a serial slave interface that has already turned the wire protocol into whole bytes and start/stop events. It parses each framed write: a device-select byte, two internal address bytes, then one or more data words. Each completed word becomes one write toward one of five targets: the parameter memory, the program memory, the 16-bit register bank, the 8-bit register bank or the single capture register.

A word is sent as a whole number of bytes, most significant byte first, with its unused upper bits zero. How many bytes make one word depends on the region that holds the current internal address. After each word the address steps up by one. When a long transfer walks from one region into the next, the expected word length switches with it. Unused padding bits are removed from the written data. If any of them arrive nonzero, a sticky error flag is raised.

Top module: `cp_frame_decoder`

## Requirements
- R1: A frame is accepted only when its first byte after a start has bits [7:1] equal to the DEV_ADDR parameter (default 7'h34) and bit 0 equal to 0 (write). Any other first byte causes the rest of the frame to be ignored, with no write, until the next start pulse.
- R2: The second byte supplies address bits [12:8] in its bits [4:0]. The third byte supplies address bits [7:0]. Nonzero bits [7:5] in the second byte set pad_err.
- R3: The default map and its codes are fixed. 0x000–0x3FF is parameter memory (target 0, 4 bytes per word). 0x400–0x7FF is program memory (target 1, 6 bytes). 0x800–0x8FF holds 16-bit registers (target 2, 2 bytes). 0x900–0x9FF holds 8-bit registers (target 3, 1 byte). 0xA00 is the capture register (target 4, 2 bytes).
- R4: Word bytes arrive most significant first. wr_data holds the low data-width bits of the concatenated bytes, zero-extended. The data widths are 28, 42, 16, 8 and 13 bits for targets 0 to 4.
- R5: For the capture register, the first data byte carries count[10:6] in bits [4:0]. The second byte carries count[5:0] in bits [7:2] and select[1:0] in bits [1:0]. The word written is {count, select}.
- R6: Within a frame, each completed word after the first is written to the previous word's address plus one.
- R7: When the incremented address falls in another region, the next word uses that region's byte count and target.
- R8: Bytes that arrive while the current address is outside every region produce no write, and the address stops advancing.
- R9: A stop pulse, or a start pulse, received part-way through a word discards the collected bytes without a write. The next frame's words are built only from its own bytes.
- R10: Nonzero padding bits set pad_err, which stays set until reset. The word is still written with the padding removed.
- R11: wr_stb is high for exactly the one clock cycle after the cycle in which the last byte of a word is accepted. wr_target, wr_addr and wr_data are valid in that same cycle.
- R12: While rst is high and right after it, wr_stb and pad_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_start | input | 1 | One-cycle pulse for a start or repeated start |
| frm_stop | input | 1 | One-cycle pulse for a stop |
| in_valid | input | 1 | in_byte holds a received byte this cycle |
| in_byte | input | 8 | Received byte |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_target | output | 3 | Target code (0 param, 1 program, 2 reg16, 3 reg8, 4 capture) |
| wr_addr | output | 13 | Internal address of the write |
| wr_data | output | 42 | Word data with padding removed, zero-extended |
| pad_err | output | 1 | Sticky flag for nonzero padding bits |

## Verification
Some properties are checked on every cycle:
- a strobe always follows an accepted byte received while the data phase was active, and it never names an unmapped target;
- the written data has no bits set above its target's width;
- the error flag never clears, and the address moves only by zero or one during the data phase;
- the byte counter stays inside the current region's word length.

Other behaviours can only be shown by the directed scenarios: the concrete byte-to-word packing per region, the length switch at the parameter/program and register/register boundaries, the rejection of foreign or read frames, and the loss of half-received words when a frame is aborted.

// File: rtl/cp_pkg.sv
package cp_pkg;
    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 13;
    localparam int DEV_W     = 7;
    localparam int PARAM_W   = 28;
    localparam int PROG_W    = 42;
    localparam int REG16_W   = 16;
    localparam int REG8_W    = 8;
    localparam int CAPT_W    = 13;
    localparam int DATA_W    = PROG_W;
    localparam int MAX_BYTES = (DATA_W + BYTE_W - 1) / BYTE_W;
    localparam int ACC_W     = MAX_BYTES * BYTE_W;
    localparam int CNT_W     = $clog2(MAX_BYTES + 1);
    localparam int WID_W     = $clog2(ACC_W + 1);

    typedef enum logic [2:0] {
        TGT_PARAM = 3'd0,
        TGT_PROG  = 3'd1,
        TGT_REG16 = 3'd2,
        TGT_REG8  = 3'd3,
        TGT_CAPT  = 3'd4,
        TGT_NONE  = 3'd7
    } tgt_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_ADRH,
        ST_ADRL,
        ST_DATA
    } phase_e;

    typedef struct packed {
        tgt_e             tgt;
        logic [WID_W-1:0] width;
        logic [CNT_W-1:0] nbytes;
    } region_t;

    function automatic logic [WID_W-1:0] width_of(tgt_e t);
        case (t)
            TGT_PARAM: return WID_W'(PARAM_W);
            TGT_PROG:  return WID_W'(PROG_W);
            TGT_REG16: return WID_W'(REG16_W);
            TGT_REG8:  return WID_W'(REG8_W);
            TGT_CAPT:  return WID_W'(CAPT_W);
            default:   return '0;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] bytes_for(logic [WID_W-1:0] w);
        return CNT_W'((int'(w) + BYTE_W - 1) / BYTE_W);
    endfunction

    function automatic region_t make_region(tgt_e t);
        region_t r;
        r.tgt    = t;
        r.width  = width_of(t);
        r.nbytes = bytes_for(r.width);
        return r;
    endfunction

    function automatic logic [ACC_W-1:0] low_mask(logic [WID_W-1:0] w);
        return (ACC_W'(1) << w) - ACC_W'(1);
    endfunction
endpackage

// File: rtl/cp_region_map.sv
module cp_region_map
    import cp_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PROG_BASE  = 13'h0400,
    parameter logic [ADDR_W-1:0] REG16_BASE = 13'h0800,
    parameter logic [ADDR_W-1:0] REG8_BASE  = 13'h0900,
    parameter logic [ADDR_W-1:0] CAPT_ADDR  = 13'h0A00
) (
    input  logic [ADDR_W-1:0] addr,
    output region_t           region
);
    // Regions are contiguous and ordered; parameter memory starts at zero.
    always_comb begin
        if (addr < PROG_BASE)        region = make_region(TGT_PARAM);
        else if (addr < REG16_BASE)  region = make_region(TGT_PROG);
        else if (addr < REG8_BASE)   region = make_region(TGT_REG16);
        else if (addr < CAPT_ADDR)   region = make_region(TGT_REG8);
        else if (addr == CAPT_ADDR)  region = make_region(TGT_CAPT);
        else                         region = make_region(TGT_NONE);
    end
endmodule

// File: rtl/cp_frame_ctrl.sv
module cp_frame_ctrl
    import cp_pkg::*;
#(
    parameter logic [DEV_W-1:0] DEV_ADDR = 7'h34
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_start,
    input  logic              frm_stop,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              word_done,
    output phase_e            phase,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              hdr_err
);
    localparam int HI_W = ADDR_W - BYTE_W;

    logic take;
    assign take = in_valid && !frm_start && !frm_stop;

    assign hdr_err = take && (phase == ST_ADRH) && (|in_byte[BYTE_W-1:HI_W]);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= ST_IDLE;
            cur_addr <= '0;
        end else if (frm_start) begin
            phase <= ST_DEV;
        end else if (frm_stop) begin
            phase <= ST_IDLE;
        end else if (take) begin
            case (phase)
                ST_DEV: begin
                    if (in_byte[BYTE_W-1:1] == DEV_ADDR && !in_byte[0])
                        phase <= ST_ADRH;
                    else
                        phase <= ST_IDLE;
                end
                ST_ADRH: begin
                    cur_addr[ADDR_W-1:BYTE_W] <= in_byte[HI_W-1:0];
                    phase <= ST_ADRL;
                end
                ST_ADRL: begin
                    cur_addr[BYTE_W-1:0] <= in_byte;
                    phase <= ST_DATA;
                end
                ST_DATA: begin
                    if (word_done) cur_addr <= cur_addr + 1'b1;
                end
                default: phase <= ST_IDLE;
            endcase
        end
    end

    p_addr_step_r6: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_DATA && $past(phase) == ST_DATA) |->
        (cur_addr == $past(cur_addr) || cur_addr == $past(cur_addr) + 1'b1));

    p_header_gate_r1: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_ADRH && $past(phase) != ST_ADRH) |->
        ($past(phase) == ST_DEV && $past(in_byte[BYTE_W-1:1]) == DEV_ADDR && !$past(in_byte[0])));
endmodule

// File: rtl/cp_word_asm.sv
module cp_word_asm
    import cp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              byte_en,
    input  logic [BYTE_W-1:0] in_byte,
    input  region_t           region,
    input  logic [ADDR_W-1:0] cur_addr,
    output logic              word_done,
    output logic              pad_bad,
    output logic              wr_stb,
    output tgt_e              wr_tgt,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] full;
    logic [ACC_W-1:0] mask;
    logic [CNT_W-1:0] cnt;

    assign full      = {acc[ACC_W-BYTE_W-1:0], in_byte};
    assign mask      = low_mask(region.width);
    assign word_done = byte_en && (cnt == region.nbytes - 1'b1);
    assign pad_bad   = word_done && (|(full & ~mask));

    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= '0;
            cnt     <= '0;
            wr_stb  <= 1'b0;
            wr_tgt  <= TGT_NONE;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= word_done;
            if (clr) begin
                acc <= '0;
                cnt <= '0;
            end else if (byte_en) begin
                if (word_done) begin
                    acc     <= '0;
                    cnt     <= '0;
                    wr_tgt  <= region.tgt;
                    wr_addr <= cur_addr;
                    wr_data <= DATA_W'(full & mask);
                end else begin
                    acc <= full;
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        byte_en |-> (cnt < region.nbytes));
endmodule

// File: rtl/cp_frame_decoder.sv
module cp_frame_decoder
    import cp_pkg::*;
#(
    parameter logic [DEV_W-1:0]  DEV_ADDR   = 7'h34,
    parameter logic [ADDR_W-1:0] PROG_BASE  = 13'h0400,
    parameter logic [ADDR_W-1:0] REG16_BASE = 13'h0800,
    parameter logic [ADDR_W-1:0] REG8_BASE  = 13'h0900,
    parameter logic [ADDR_W-1:0] CAPT_ADDR  = 13'h0A00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_start,
    input  logic              frm_stop,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              wr_stb,
    output logic [2:0]        wr_target,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              pad_err
);
    phase_e            phase;
    logic [ADDR_W-1:0] cur_addr;
    logic              hdr_err;
    logic              word_done;
    logic              pad_bad;
    logic              byte_en;
    region_t           region;
    tgt_e              wr_tgt;

    cp_frame_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .frm_start (frm_start),
        .frm_stop  (frm_stop),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .word_done (word_done),
        .phase     (phase),
        .cur_addr  (cur_addr),
        .hdr_err   (hdr_err)
    );

    cp_region_map #(
        .PROG_BASE  (PROG_BASE),
        .REG16_BASE (REG16_BASE),
        .REG8_BASE  (REG8_BASE),
        .CAPT_ADDR  (CAPT_ADDR)
    ) u_map (
        .addr   (cur_addr),
        .region (region)
    );

    assign byte_en = in_valid && !frm_start && !frm_stop &&
                     (phase == ST_DATA) && (region.tgt != TGT_NONE);

    cp_word_asm u_asm (
        .clk       (clk),
        .rst       (rst),
        .clr       (frm_start || frm_stop),
        .byte_en   (byte_en),
        .in_byte   (in_byte),
        .region    (region),
        .cur_addr  (cur_addr),
        .word_done (word_done),
        .pad_bad   (pad_bad),
        .wr_stb    (wr_stb),
        .wr_tgt    (wr_tgt),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    assign wr_target = wr_tgt;

    always_ff @(posedge clk) begin
        if (rst)                    pad_err <= 1'b0;
        else if (pad_bad || hdr_err) pad_err <= 1'b1;
    end

    p_stb_after_byte_r11: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> $past(in_valid));

    p_stb_in_data_r1: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> $past(phase) == ST_DATA);

    p_mapped_target_r8: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> wr_tgt != TGT_NONE);

    p_pad_dropped_r10: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> ((ACC_W'(wr_data) & ~low_mask(width_of(wr_tgt))) == '0));

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        pad_err |=> pad_err);
endmodule

// File: tb/cp_frame_decoder_tb.sv
module cp_frame_decoder_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frm_start = 1'b0;
    logic        frm_stop = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        wr_stb;
    logic [2:0]  wr_target;
    logic [12:0] wr_addr;
    logic [41:0] wr_data;
    logic        pad_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [7:0] DEV_WR = 8'h68;   // 7'h34, write

    always #10 clk = ~clk;   // 50 MHz

    cp_frame_decoder u_dut (
        .clk(clk), .rst(rst), .frm_start(frm_start), .frm_stop(frm_stop),
        .in_valid(in_valid), .in_byte(in_byte), .wr_stb(wr_stb),
        .wr_target(wr_target), .wr_addr(wr_addr), .wr_data(wr_data),
        .pad_err(pad_err)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R12 stb in reset", 64'(wr_stb), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R12 stb after reset", 64'(wr_stb), 64'd0);
        chk("R12 pad_err after reset", 64'(pad_err), 64'd0);
    endtask

    task automatic pulse_start();
        @(negedge clk); frm_start = 1'b1;
        @(negedge clk); frm_start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); frm_stop = 1'b1;
        @(negedge clk); frm_stop = 1'b0;
    endtask

    // Byte is accepted at the posedge inside this task; outputs are sampled
    // at the following negedge, where a strobe for that byte is visible.
    task automatic send(logic [7:0] b);
        @(negedge clk); in_valid = 1'b1; in_byte = b;
        @(negedge clk); in_valid = 1'b0;
    endtask

    task automatic header(logic [7:0] dev, logic [12:0] addr);
        pulse_start();
        send(dev);
        send({3'b000, addr[12:8]});
        send(addr[7:0]);
    endtask

    task automatic expect_none(string req);
        chk({req, " no strobe"}, 64'(wr_stb), 64'd0);
    endtask

    task automatic expect_wr(string req, logic [2:0] t, logic [12:0] a, logic [41:0] d);
        chk({req, " strobe"}, 64'(wr_stb), 64'd1);
        chk({req, " target"}, 64'(wr_target), 64'(t));
        chk({req, " addr"},   64'(wr_addr), 64'(a));
        chk({req, " data"},   64'(wr_data), 64'(d));
    endtask

    // Sends n bytes of a word, checking that only the last one strobes.
    task automatic send_word(string req, logic [47:0] w, int n);
        for (int i = n - 1; i >= 0; i--) begin
            send(w[i*8 +: 8]);
            if (i != 0) expect_none(req);
        end
    endtask

    task automatic t_param_single();
        header(DEV_WR, 13'h0010);
        send_word("R4", 48'h0ABCDEF1, 4);
        expect_wr("R3 R4 R11 param", 3'd0, 13'h0010, 42'h0ABCDEF1);
        @(negedge clk);
        chk("R11 strobe one cycle", 64'(wr_stb), 64'd0);
        pulse_stop();
    endtask

    task automatic t_prog_single();
        header(DEV_WR, 13'h0456);
        send_word("R3", 48'h03FF12345678, 6);
        expect_wr("R2 R3 R4 prog", 3'd1, 13'h0456, 42'h3FF12345678);
        pulse_stop();
    endtask

    task automatic t_reg_burst();
        header(DEV_WR, 13'h08FF);
        send_word("R6", 48'h1234, 2);
        expect_wr("R3 reg16", 3'd2, 13'h08FF, 42'h1234);
        send(8'h56);
        expect_wr("R7 reg16->reg8", 3'd3, 13'h0900, 42'h56);
        send(8'h78);
        expect_wr("R6 reg8 step", 3'd3, 13'h0901, 42'h78);
        pulse_stop();
    endtask

    task automatic t_param_to_prog();
        header(DEV_WR, 13'h03FF);
        send_word("R7", 48'h01020304, 4);
        expect_wr("R7 last param", 3'd0, 13'h03FF, 42'h01020304);
        send_word("R7", 48'h00AABBCCDDEE, 6);
        expect_wr("R7 first prog", 3'd1, 13'h0400, 42'h0AABBCCDDEE);
        pulse_stop();
    endtask

    task automatic t_capture_and_unmapped();
        header(DEV_WR, 13'h0A00);
        send(8'h15);
        expect_none("R5");
        send(8'hB7);
        expect_wr("R5 capture", 3'd4, 13'h0A00, 42'h15B7);
        for (int i = 0; i < 4; i++) begin
            send(8'h11);
            expect_none("R8 unmapped");
        end
        pulse_stop();
    endtask

    task automatic t_reject();
        header(8'h50, 13'h0900);
        send(8'h99);
        expect_none("R1 wrong device");
        header(DEV_WR | 8'h01, 13'h0900);
        send(8'h99);
        expect_none("R1 read frame");
        header(DEV_WR, 13'h0900);
        send(8'h5A);
        expect_wr("R1 accepted after reject", 3'd3, 13'h0900, 42'h5A);
        pulse_stop();
    endtask

    task automatic t_abort();
        header(DEV_WR, 13'h0020);
        send(8'hFF); send(8'hEE);
        pulse_stop();
        expect_none("R9 stop mid-word");
        header(DEV_WR, 13'h0025);
        send(8'hDD);
        pulse_start();
        send(DEV_WR); send(8'h00); send(8'h30);
        send_word("R9", 48'h01020304, 4);
        expect_wr("R9 fresh word", 3'd0, 13'h0030, 42'h01020304);
        pulse_stop();
        chk("R10 no error on clean traffic", 64'(pad_err), 64'd0);
    endtask

    task automatic t_padding();
        header(DEV_WR, 13'h0040);
        send_word("R10", 48'hF1234567, 4);
        expect_wr("R10 padding dropped", 3'd0, 13'h0040, 42'h1234567);
        chk("R10 pad_err set", 64'(pad_err), 64'd1);
        header(DEV_WR, 13'h0900);
        send(8'h01);
        expect_wr("R10 later write", 3'd3, 13'h0900, 42'h01);
        chk("R10 pad_err sticky", 64'(pad_err), 64'd1);
        pulse_stop();
    endtask

    task automatic t_hdr_pad();
        do_reset();
        pulse_start();
        send(DEV_WR); send(8'hA0); send(8'h05);
        send_word("R2", 48'h00000077, 4);
        expect_wr("R2 upper bits ignored", 3'd0, 13'h0005, 42'h77);
        chk("R2 pad_err from address byte", 64'(pad_err), 64'd1);
        pulse_stop();
    endtask

    initial begin
        do_reset();
        t_param_single();
        t_prog_single();
        t_reg_burst();
        t_param_to_prog();
        t_capture_and_unmapped();
        t_reject();
        t_abort();
        t_padding();
        t_hdr_pad();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule